// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block takes back an I2C bus after a target has been left holding SDA low, for example when a transfer was cut short partway through a byte. On a start request it holds the main I2C controller in reset and lets go of both bus lines. Both line levels pass through a synchroniser before they are used. If the bus is still not free after a settling interval, the sequencer clocks the target by pulling SCL low and releasing it again. It checks the bus before each new pulse and stops as soon as both lines read high.

The number of pulses has a fixed upper limit. When the bus frees up, or when the limit is used up, the sequencer releases the controller so that it can be reinitialised. It then raises a done indication, with a failure flag if the bus never became free. SDA is never driven by this block. Generating a STOP condition and moving data are left to the main controller.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), scl_low, ctrl_hold, done and failed are all 0.
- R2: When start is sampled high while idle or finished, SCL is released and ctrl_hold goes to 1 and stays at 1 until done rises. The first bus check takes place PULSE_CYCLES cycles after start is sampled.
- R3: The bus counts as free only when both SCL and SDA read high after a SYNC_STAGES-deep synchroniser. If the bus is free at the first check, the run ends with no SCL pulse and failed = 0.
- R4: Each recovery pulse drives scl_low = 1 for exactly PULSE_CYCLES cycles. SCL is then released for exactly PULSE_CYCLES cycles before the next bus check.
- R5: The bus is checked before every pulse. Once it reads free, no further pulse is issued, so a target that lets go after k pulses (k ≤ MAX_TRIES) gets exactly k pulses and failed = 0.
- R6: At most MAX_TRIES pulses are issued per run. If the bus is still not free at the check after the last one, the run ends with failed = 1. This covers SCL held low by another device.
- R7: The run ends with done = 1 exactly PULSE_CYCLES + 1 + n·(2·PULSE_CYCLES + 1) cycles after start is sampled, where n is the number of pulses. At the same cycle ctrl_hold drops to 0 and scl_low is 0.
- R8: done and failed keep their values until the next start. A new start clears them and begins a fresh run with the pulse count reset.
- R9: start has no effect while a run is in progress: the pulse count and the completion cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a recovery run |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | 1 pulls SCL low (open-drain enable) |
| ctrl_hold | output | 1 | Holds the main controller in reset during a run |
| done | output | 1 | Run finished; controller may be reinitialised |
| failed | output | 1 | Bus was not free when the run finished |

## Verification
The assertions assume that the line levels reach the block only through its synchroniser. They also assume that start can arrive at any time, including in the middle of a run. A line may change at any cycle, but a success is only credited when the synchronised levels were both high in the cycle of the check. The bench models an open-drain bus in which a target releases SDA after a chosen number of SCL rising edges. It sweeps that number from zero to one past the pulse limit, and it adds a run with SCL held low throughout. It changes the line levels only on the falling clock edge, so every transition is a clean synchroniser input. The pulse high phase is longer than the synchroniser depth, so a release is seen before the next check.

// File: rtl/i2c_unjam_pkg.sv
// Package: shared state encoding for the bus recovery sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package i2c_unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RELEASE = 3'd1,
        ST_CHECK   = 3'd2,
        ST_LOW     = 3'd3,
        ST_HIGH    = 3'd4,
        ST_FINISH  = 3'd5
    } unjam_state_t;

endpackage

// File: rtl/i2c_unjam_sync.sv
// Module: multi-stage synchroniser for the SCL and SDA levels, plus the
// bus-free decode on the synchronised values.
// Assumes: inputs may be asynchronous; STAGES >= 2. Resets to the idle-bus
// level (both high).
module i2c_unjam_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_free
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;

    // Shift each line level through its chain of stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    // The bus is free only when both synchronised lines are high.
    always_comb begin
        bus_free = scl_pipe[STAGES-1] & sda_pipe[STAGES-1];
    end
endmodule

// File: rtl/i2c_unjam_timer.sv
// Module: down-counting phase timer. A load starts a phase of LENGTH cycles;
// expired is high in the last cycle of that phase and stays high afterwards.
// Assumes: LENGTH >= 1; load is a single-cycle request from the sequencer.
module i2c_unjam_timer #(
    parameter int LENGTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (LENGTH > 1) ? $clog2(LENGTH) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(LENGTH - 1);

    logic [CW-1:0] count;

    // Load the phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= RELOAD;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Flag the last cycle of the phase.
    always_comb begin
        expired = (count == '0);
    end

    assert_reload_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == RELOAD));
endmodule

// File: rtl/i2c_unjam_fsm.sv
// Module: recovery sequencer. It releases the bus, checks that it is free,
// and issues bounded SCL pulses with a check before each pulse.
// Assumes: bus_free comes from a synchroniser; phase_done comes from a timer
// that is loaded on the phase_load pulse.
module i2c_unjam_fsm
    import i2c_unjam_pkg::*;
#(
    parameter int MAX_TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bus_free,
    input  logic phase_done,
    output logic phase_load,
    output logic scl_low,
    output logic ctrl_hold,
    output logic done,
    output logic failed
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] TRY_LIMIT = TW'(MAX_TRIES);

    unjam_state_t state, state_nx;
    logic [TW-1:0] tries;
    logic          fail_q;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (start) state_nx = ST_RELEASE;
            ST_RELEASE: if (phase_done) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (bus_free || (tries == TRY_LIMIT)) state_nx = ST_FINISH;
                else                                   state_nx = ST_LOW;
            end
            ST_LOW:     if (phase_done) state_nx = ST_HIGH;
            ST_HIGH:    if (phase_done) state_nx = ST_CHECK;
            ST_FINISH:  if (start) state_nx = ST_RELEASE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Start a timed phase on entry to any timed state.
    always_comb begin
        phase_load = (state_nx != state) &&
                     ((state_nx == ST_RELEASE) || (state_nx == ST_LOW) ||
                      (state_nx == ST_HIGH));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pulse counter: cleared at the start of a run, bumped at each completed pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (state_nx == ST_RELEASE && state != ST_RELEASE) begin
            tries <= '0;
        end else if (state == ST_HIGH && phase_done) begin
            tries <= tries + 1'b1;
        end
    end

    // Outcome flag: set at the final check and held until the next run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (state == ST_CHECK && state_nx == ST_FINISH) begin
            fail_q <= !bus_free;
        end else if (state_nx == ST_RELEASE && state != ST_RELEASE) begin
            fail_q <= 1'b0;
        end
    end

    // Output decode from the state register.
    always_comb begin
        scl_low   = (state == ST_LOW);
        ctrl_hold = (state != ST_IDLE) && (state != ST_FINISH);
        done      = (state == ST_FINISH);
        failed    = fail_q && (state == ST_FINISH);
    end

    assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_LIMIT);
    assert_no_pulse_past_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && tries == TRY_LIMIT) |=> !scl_low);
    assert_fail_only_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> done);
    assert_success_saw_free_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !failed) |-> $past(bus_free));
    assert_hold_while_driving_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low |-> ctrl_hold);
    assert_early_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && bus_free) |=> (done && !scl_low));
    assert_run_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hold && state != ST_RELEASE && start) |=> (state != ST_RELEASE));
    assert_outcome_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(failed)));
endmodule

// File: rtl/i2c_bus_unjam.sv
// Module: top of the I2C stuck-bus recovery sequencer. It joins the
// synchroniser, the phase timer and the sequencer.
// Assumes: scl_low drives an open-drain SCL pad; SDA is never driven here.
// PULSE_CYCLES sets each SCL phase in system-clock cycles and must exceed
// SYNC_STAGES so that a released line is seen before the next check.
module i2c_bus_unjam #(
    parameter int PULSE_CYCLES = 500,
    parameter int MAX_TRIES    = 100,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_low,
    output logic ctrl_hold,
    output logic done,
    output logic failed
);
    logic bus_free;
    logic phase_load;
    logic phase_done;

    i2c_unjam_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .bus_free (bus_free)
    );

    i2c_unjam_timer #(.LENGTH(PULSE_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (phase_load),
        .expired (phase_done)
    );

    i2c_unjam_fsm #(.MAX_TRIES(MAX_TRIES)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bus_free   (bus_free),
        .phase_done (phase_done),
        .phase_load (phase_load),
        .scl_low    (scl_low),
        .ctrl_hold  (ctrl_hold),
        .done       (done),
        .failed     (failed)
    );

    assert_release_on_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!scl_low && !ctrl_hold && !done && !failed));
endmodule

// File: tb/i2c_bus_unjam_tb_top.sv
// Bench: sweeps the number of SCL rising edges a modelled target needs before
// it lets go of SDA, and adds a run with SCL held low throughout.
module i2c_bus_unjam_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4;
    localparam int M = 5;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_stuck = 1'b0;
    logic sda_hold = 1'b0;
    logic scl_low, ctrl_hold, done, failed;
    logic scl_line, sda_line;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;

    assign scl_line = !scl_low && !scl_stuck;
    assign sda_line = !sda_hold;

    i2c_bus_unjam #(.PULSE_CYCLES(P), .MAX_TRIES(M), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_low   (scl_low),
        .ctrl_hold (ctrl_hold),
        .done      (done),
        .failed    (failed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // One recovery run: the target needs k SCL rising edges; stuck holds SCL low;
    // inject pulses start during a low phase.
    task automatic run_case(input int k, input bit stuck, input bit inject);
        int cnt = 0;
        int rises = 0;
        int run_len = 0;
        int lows = 0;
        bit prev_low = 1'b0;
        bit hold_ok = 1'b1;
        bit width_ok = 1'b1;
        int exp_n;
        bit exp_fail;
        exp_fail = stuck || (k > M);
        exp_n = stuck ? M : ((k > M) ? M : k);
        @(negedge clk);
        scl_stuck = stuck;
        sda_hold = (k > 0);
        start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = (inject && cnt == P + 3);
            if (done) break;
            if (!ctrl_hold) hold_ok = 1'b0;
            if (scl_low) run_len++;
            else if (run_len > 0) begin
                if (run_len != P) width_ok = 1'b0;
                lows++;
                run_len = 0;
            end
            if (prev_low && !scl_low && !stuck) rises++;
            prev_low = scl_low;
            if (rises >= k) sda_hold = 1'b0;
            if (cnt > 5000) break;
            @(posedge clk);
            cnt++;
        end
        start = 1'b0;
        check(hold_ok, "R2 hold during run", hold_ok, 1);
        check(width_ok, "R4 low width", width_ok, 1);
        check(lows == exp_n, (k > M || stuck) ? "R6 pulse count" : "R5 pulse count", lows, exp_n);
        check(failed == exp_fail, exp_n == 0 ? "R3 outcome" : "R6 outcome", failed, exp_fail);
        check(cnt == P + 1 + exp_n*(2*P + 1), inject ? "R9 latency with start" : "R7 latency",
              cnt, P + 1 + exp_n*(2*P + 1));
        check(!ctrl_hold && !scl_low, "R7 hold released", ctrl_hold, 0);
        repeat (3) @(negedge clk);
        check(done && failed == exp_fail, "R8 outcome held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_low && !ctrl_hold && !done && !failed, "R1 reset state",
              {scl_low, ctrl_hold, done, failed}, 0);
        for (int k = 0; k <= M + 1; k++) run_case(k, 1'b0, 1'b0);
        run_case(0, 1'b1, 1'b0);
        run_case(3, 1'b0, 1'b0);
        run_case(2, 1'b0, 1'b1);
        run_case(M + 1, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!done && !failed && !ctrl_hold, "R1 reset after run", done, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule